// File: doc/BRIEF.md
# Signed Magnitude Comparator

This block takes two 64-bit two's-complement operands and answers one question: is the absolute value of the second operand strictly larger than the absolute value of the first? It is purely combinational. It never forms either absolute value. Instead it picks two addends and a carry-in according to the two signs, and one 65-bit addition then settles the answer in its top bit.

The hard case is a negative first operand with a non-negative second operand. Here the two inverted operands are first folded by a carry-save stage, with a bitwise XOR for the sum and a shifted AND with a forced low one for the carries. Only then does the final adder run. The other three sign cases feed plain or inverted operands straight to the adder.

The block suits datapaths that must order signed values by magnitude, such as selecting the larger operand before an alignment shift. It has no clock, so the result is valid once the operands have settled.

Top module: `mag_cmp_signed`

## Requirements
- R1: Each operand is read as a signed 64-bit value whose sign is bit 63. With a = all ones (-1) and b = 2, the output is 1.
- R2: The output `b_larger` is 1 exactly when |b| > |a|, and 0 otherwise.
- R3: Equal magnitudes give 0. This covers a == b, a == -b, and both operands zero.
- R4: The most negative value (-2^63) counts as magnitude 2^63:
  - the pairs (a=-2^63, b=0), (a=-2^63, b=2^63-1) and (a=-2^63, b=-2^63) give 0;
  - the pairs (a=0, b=-2^63) and (a=2^63-1, b=-2^63) give 1.
- R5: When a is negative and b is non-negative, a carry-save stage feeds the adder:
  - the first addend is ~a XOR ~b;
  - the second addend is (~a AND ~b) shifted left by one, with bit 0 set;
  - the carry-in is 1;
  - the two addends then sum to exactly ~a + ~b + 1;
  - the output is correct for all such operands.
- R6: In the other three sign cases the adder receives the following, and the output is correct for all such operands:
  - both operands non-negative: a, ~b and carry-in 1;
  - both operands negative: ~a, b and carry-in 1;
  - a non-negative and b negative: a, b and carry-in 0.
- R7: The low 64 bits of the 65-bit sum equal (|a| - |b|) mod 2^64. The output is the inverse of bit 64 of that sum and follows any input change with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First signed operand |
| b | input | 64 | Second signed operand |
| b_larger | output | 1 | 1 when the magnitude of b strictly exceeds that of a |

## Verification
Immediate assertions re-check the design whenever an operand changes:
- the output against an independent magnitude comparison;
- zero output for equal magnitudes;
- the exact carry-save sum identity in the mixed-sign case;
- the low-order bits of the sum against the magnitude difference.

Only the bench's chosen scenarios show the specific corner pairs around -2^63 and 2^63-1, and the sign-bit reading of R1. The same holds for coverage of all four sign combinations with random vectors, and for the output following back-to-back input changes.

// File: rtl/mag_cmp_pkg.sv
// Shared constants and types for the signed magnitude comparator.
// Assumes operands are two's-complement words of OPERAND_W bits.
package mag_cmp_pkg;
    localparam int unsigned OPERAND_W = 64;

    // Sign combination of (a, b); the encoding is {sign_a, sign_b}.
    typedef enum logic [1:0] {
        SC_POS_POS = 2'b00,
        SC_POS_NEG = 2'b01,
        SC_NEG_POS = 2'b10,
        SC_NEG_NEG = 2'b11
    } sign_case_e;
endpackage

// File: rtl/mag_cmp_csa.sv
// Carry-save fold of two words into a sum word and a carry word.
// The carry word is shifted left by one with bit 0 forced to 1, so that
// sum + carry == x + y + 1 whenever the top bits of x and y are not both 1.
module mag_cmp_csa #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    // Forced low carry that stands in for the +1.
    assign c[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit sum without carry propagation.
        assign s[i] = x[i] ^ y[i];
        if (i < W - 1) begin : g_carry
            // Generated carry moves one place up.
            assign c[i+1] = x[i] & y[i];
        end
    end
endmodule

// File: rtl/mag_cmp_addend_sel.sv
// Chooses the two adder inputs and the carry-in from the operand signs.
// Assumes the sign of each operand is its most significant bit.
module mag_cmp_addend_sel
    import mag_cmp_pkg::*;
#(
    parameter int unsigned W = OPERAND_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] add_lo,
    output logic [W-1:0] add_hi,
    output logic         carry_in
);
    logic [W-1:0] inv_a;
    logic [W-1:0] inv_b;
    logic [W-1:0] csa_s;
    logic [W-1:0] csa_c;
    sign_case_e   sc;

    assign inv_a = ~a;
    assign inv_b = ~b;

    // Mixed-sign pre-add of the inverted operands.
    mag_cmp_csa #(.W(W)) u_csa (
        .x (inv_a),
        .y (inv_b),
        .s (csa_s),
        .c (csa_c)
    );

    // Sign-case decode and addend steering.
    always_comb begin
        sc = sign_case_e'({a[W-1], b[W-1]});
        unique case (sc)
            SC_NEG_POS: begin
                add_lo   = csa_s;
                add_hi   = csa_c;
                carry_in = 1'b1;
            end
            SC_POS_POS: begin
                add_lo   = a;
                add_hi   = inv_b;
                carry_in = 1'b1;
            end
            SC_NEG_NEG: begin
                add_lo   = inv_a;
                add_hi   = b;
                carry_in = 1'b1;
            end
            default: begin
                add_lo   = a;
                add_hi   = b;
                carry_in = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mag_cmp_adder.sv
// Full-width adder with one extra output bit for the carry-out.
// The result's top bit is clear exactly when the second magnitude wins.
module mag_cmp_adder #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W:0]   diff
);
    // Single carry-propagate addition.
    assign diff = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
endmodule

// File: rtl/mag_cmp_signed.sv
// Top of the signed magnitude comparator: b_larger = (|b| > |a|).
// Purely combinational; no absolute value is ever formed.
module mag_cmp_signed
    import mag_cmp_pkg::*;
#(
    parameter int unsigned W = OPERAND_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         b_larger
);
    logic [W-1:0] add_lo;
    logic [W-1:0] add_hi;
    logic         carry_in;
    logic [W:0]   diff;

    // Operand steering per sign case.
    mag_cmp_addend_sel #(.W(W)) u_sel (
        .a        (a),
        .b        (b),
        .add_lo   (add_lo),
        .add_hi   (add_hi),
        .carry_in (carry_in)
    );

    // The one wide addition.
    mag_cmp_adder #(.W(W)) u_add (
        .x    (add_lo),
        .y    (add_hi),
        .cin  (carry_in),
        .diff (diff)
    );

    // Decision from the carry-out.
    assign b_larger = ~diff[W];
endmodule

// File: rtl/mag_cmp_signed_chk.sv
// Checker for mag_cmp_signed, bound into every instance.
// Uses immediate assertions because the block has no clock.
module mag_cmp_signed_chk #(
    parameter int unsigned W = 64
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [W-1:0] add_lo,
    input logic [W-1:0] add_hi,
    input logic         carry_in,
    input logic [W:0]   diff,
    input logic         b_larger
);
    logic [W:0] mag_a;
    logic [W:0] mag_b;
    logic [W:0] pre_sum;
    logic [W:0] inv_sum;

    // Independent magnitudes in one extra bit.
    always_comb begin
        mag_a   = a[W-1] ? (~{a[W-1], a} + 1'b1) : {1'b0, a};
        mag_b   = b[W-1] ? (~{b[W-1], b} + 1'b1) : {1'b0, b};
        pre_sum = {1'b0, add_lo} + {1'b0, add_hi};
        inv_sum = {1'b0, ~a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    end

    // Property checks on every operand change.
    always_comb begin
        // R2
        order_match_chk: assert (b_larger == (mag_b > mag_a))
            else $error("order mismatch a=%h b=%h", a, b);
        // R3
        equal_mag_chk: assert (!(mag_a == mag_b) || !b_larger)
            else $error("equal magnitudes flagged a=%h b=%h", a, b);
        // R5
        csa_identity_chk: assert (!(a[W-1] && !b[W-1]) || (carry_in && pre_sum == inv_sum))
            else $error("carry-save identity broken a=%h b=%h", a, b);
        // R7
        low_diff_chk: assert (diff[W-1:0] == (mag_a[W-1:0] - mag_b[W-1:0]))
            else $error("low difference bits wrong a=%h b=%h", a, b);
    end
endmodule

bind mag_cmp_signed mag_cmp_signed_chk #(.W(W)) u_chk (
    .a        (a),
    .b        (b),
    .add_lo   (add_lo),
    .add_hi   (add_hi),
    .carry_in (carry_in),
    .diff     (diff),
    .b_larger (b_larger)
);

// File: tb/sim_mag_cmp_signed.sv
// Scoreboard bench: a driver applies operand pairs on the rising edge and
// queues the expected bit; a monitor pops and compares on the falling edge.
module sim_mag_cmp_signed;
    localparam logic [63:0] MIN_V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX_V = 64'h7FFF_FFFF_FFFF_FFFF;

    typedef struct {
        logic [63:0] a;
        logic [63:0] b;
        logic        exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        b_larger;
    item_t       sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    mag_cmp_signed u0 (.a(a), .b(b), .b_larger(b_larger));

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Reference: 128-bit signed magnitudes.
    function automatic logic ref_gt(input logic [63:0] x, input logic [63:0] y);
        logic signed [127:0] sx;
        logic signed [127:0] sy;
        sx = {{64{x[63]}}, x};
        sy = {{64{y[63]}}, y};
        if (sx < 0) sx = -sx;
        if (sy < 0) sy = -sy;
        return sy > sx;
    endfunction

    function automatic logic [63:0] rnd64(input bit sgn);
        logic [63:0] v;
        v = {$urandom(), $urandom()};
        v[63] = sgn;
        return v;
    endfunction

    // Driver: applies a pair and queues the expected result.
    task automatic drive(input logic [63:0] xa, input logic [63:0] xb, input string tag);
        item_t it;
        @(posedge clk);
        a = xa;
        b = xb;
        it.a = xa;
        it.b = xb;
        it.exp = ref_gt(xa, xb);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares settled output against the queued item.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (b_larger !== it.exp || a !== it.a || b !== it.b) begin
                n_bad++;
                $display("FAIL %s: a=%h b=%h got %0b expected %0b",
                         it.tag, it.a, it.b, b_larger, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R3 idle state: zero against zero
        drive('0, '0, "R3");
        // R1 sign is bit 63: -1 against 2
        drive('1, 64'd2, "R1");
        drive(64'd2, '1, "R1");
        // R2 simple orderings
        drive(64'd5, 64'd6, "R2");
        drive(64'd6, 64'd5, "R2");
        drive(-64'd7, 64'd6, "R2");
        // R3 equal magnitudes
        drive(64'd9, -64'd9, "R3");
        drive(-64'd9, 64'd9, "R3");
        drive(-64'd9, -64'd9, "R3");
        drive(MAX_V, MAX_V, "R3");
        // R4 most negative value
        drive(MIN_V, '0, "R4");
        drive('0, MIN_V, "R4");
        drive(MIN_V, MAX_V, "R4");
        drive(MAX_V, MIN_V, "R4");
        drive(MIN_V, MIN_V, "R4");
        drive(MIN_V + 64'd1, MAX_V, "R4");
        // R5 mixed-sign case: a negative, b non-negative
        for (int i = 0; i < 600; i++) drive(rnd64(1'b1), rnd64(1'b0), "R5");
        for (int i = 0; i < 100; i++) begin
            logic [63:0] v;
            v = rnd64(1'b0);
            drive(-v, v + 64'(i % 3) - 64'd1, "R5");
        end
        // R6 remaining sign combinations
        for (int i = 0; i < 600; i++) drive(rnd64(1'b0), rnd64(1'b0), "R6");
        for (int i = 0; i < 600; i++) drive(rnd64(1'b1), rnd64(1'b1), "R6");
        for (int i = 0; i < 600; i++) drive(rnd64(1'b0), rnd64(1'b1), "R6");
        // R3 random negated pairs
        for (int i = 0; i < 100; i++) begin
            logic [63:0] v;
            v = rnd64(i[0]);
            drive(v, -v, "R3");
        end
        // R7 output follows back-to-back changes
        for (int i = 0; i < 50; i++) begin
            drive(64'd100, 64'd101, "R7");
            drive(64'd101, -64'd100, "R7");
        end
        @(posedge clk);
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule